// File: doc/BRIEF.md
# Stereo Stepped Volume Stage with Soft Mute

This block scales a two-channel stream of signed audio samples by a per-channel gain. Each channel has an 8-bit volume code. Code 0 passes the sample at unity. Each step up in code adds half a decibel of attenuation, reaching about −127 dB at code 254. The all-ones code silences the channel outright. The gain is built from a twelve-entry mantissa table that covers one 6 dB octave, followed by a right shift of one place per twelve codes. The product is truncated back to the sample width and saturated.

A soft-mute request moves the applied codes of both channels up by one step per sample frame until both reach mute. Releasing the request moves them back down one step per frame to the programmed codes. A busy flag is high while a ramp runs, and a muted flag is high while both channels are held at mute.

In an alternative mode, both channels take their code from a sampled control level instead of the code inputs. That level is smoothed by a first-order shift-based low-pass filter. With a shift of k and a control update period T, the time constant is about 2^k·T, so k is chosen to give roughly 10 ms at the actual update rate.

Top module: `stereo_volume`

## Requirements
- R1: After reset, outL, outR and outValid are 0, rampBusy and softMuted are 0, and the applied code of both channels is 0 (unity gain).
- R2: For an applied code c in 0..254 the gain is M[c mod 12] >> (c div 12), with M = 32768, 30935, 29205, 27571, 26029, 24573, 23198, 21900, 20675, 19519, 18427, 17396 (Q1.15). The output is floor(sample·gain / 32768), saturated to 16-bit signed.
- R3: Applied code 255 gives an output of exactly 0 for any sample.
- R4: The left and right channels use their own codes and samples, with no effect on each other.
- R5: The applied code is updated only on a frame (sampleValid high). A frame is scaled with the code applied before it and then loads the new code, so a code change first shows in the second frame after it.
- R6: On each frame with softMute high, each channel's applied code rises by one until it reaches 255. rampBusy is high while either channel is below 255. Once both are at 255, softMuted is high and rampBusy is low.
- R7: On each frame with softMute low after a mute, each applied code above its target falls by one, and a code at or below its target is set to the target. When both channels have reached their targets, rampBusy goes low and the codes follow their targets directly again.
- R8: With analogMode high, both targets are filt >> K (K = 4), where filt starts at 0 and on each analogValid becomes filt + ((level·2^K − filt) >>> K). From 0, one update with level 20 gives code 1, and repeated updates settle at code 19.
- R9: outValid is high in the cycle after each frame and low otherwise, and outL/outR hold their values between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Frame strobe, samples valid |
| inL | input | 16 | Left input sample, signed |
| inR | input | 16 | Right input sample, signed |
| volCodeL | input | 8 | Left volume code (255 = mute) |
| volCodeR | input | 8 | Right volume code (255 = mute) |
| softMute | input | 1 | Soft-mute request level |
| analogMode | input | 1 | Take both codes from the filtered control level |
| analogValid | input | 1 | Control level update strobe |
| analogLevel | input | 8 | Sampled control level (code units) |
| outL | output | 16 | Scaled left sample |
| outR | output | 16 | Scaled right sample |
| outValid | output | 1 | Output frame strobe |
| rampBusy | output | 1 | Mute or demute ramp in progress |
| softMuted | output | 1 | Both channels held at mute by soft mute |

## Verification
The assertions assume that sampleValid is a single-cycle strobe, that softMute and the code inputs change only between frames, and that analogValid is a separate single-cycle strobe. The bench drives every input on the falling clock edge and holds each strobe for exactly one cycle. It changes codes and the soft-mute level only between frames. It spaces frames at least one idle cycle apart, so the stability checks on the held outputs are exercised.

// File: rtl/volPkg.sv
package volPkg;
  localparam int CODE_W    = 8;
  localparam int GAIN_FRAC = 15;
  localparam int GAIN_W    = GAIN_FRAC + 1;
  localparam int OCT_STEPS = 12;
  localparam logic [CODE_W-1:0] MUTE_CODE = {CODE_W{1'b1}};

  typedef enum logic [1:0] {
    ST_NORMAL   = 2'd0,
    ST_MUTING   = 2'd1,
    ST_MUTED    = 2'd2,
    ST_DEMUTING = 2'd3
  } muteState_t;

  // strobes from control to datapath: frame and the codes applied to it
  typedef struct packed {
    logic              frame;
    logic [CODE_W-1:0] codeL;
    logic [CODE_W-1:0] codeR;
  } volStrobes_t;

  // half-dB step law: mantissa for one octave, then a shift per octave
  function automatic logic [GAIN_W-1:0] codeToGain(input logic [CODE_W-1:0] code);
    logic [GAIN_W-1:0] mant;
    int unsigned       idx;
    int unsigned       oct;
    idx = int'(code) % OCT_STEPS;
    oct = int'(code) / OCT_STEPS;
    case (idx)
      0:  mant = 16'd32768;
      1:  mant = 16'd30935;
      2:  mant = 16'd29205;
      3:  mant = 16'd27571;
      4:  mant = 16'd26029;
      5:  mant = 16'd24573;
      6:  mant = 16'd23198;
      7:  mant = 16'd21900;
      8:  mant = 16'd20675;
      9:  mant = 16'd19519;
      10: mant = 16'd18427;
      default: mant = 16'd17396;
    endcase
    if (code == MUTE_CODE) return '0;
    return mant >> oct;
  endfunction
endpackage

// File: rtl/volCtrl.sv
module volCtrl
  import volPkg::*;
#(
  parameter int FILT_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic              softMute,
  input  logic              analogMode,
  input  logic              analogValid,
  input  logic [CODE_W-1:0] analogLevel,
  input  logic [CODE_W-1:0] volCodeL,
  input  logic [CODE_W-1:0] volCodeR,
  output volStrobes_t       strobes,
  output logic              rampBusy,
  output logic              softMuted
);
  localparam int ACC_W = CODE_W + FILT_SHIFT;

  // control-level smoothing filter
  logic [ACC_W-1:0]      filtAcc;
  logic signed [ACC_W:0] filtDiff;
  logic signed [ACC_W:0] filtSum;
  logic [CODE_W-1:0]     filtCode;

  assign filtDiff = $signed({1'b0, analogLevel, {FILT_SHIFT{1'b0}}}) - $signed({1'b0, filtAcc});
  assign filtSum  = $signed({1'b0, filtAcc}) + (filtDiff >>> FILT_SHIFT);
  assign filtCode = filtAcc[ACC_W-1:FILT_SHIFT];

  always_ff @(posedge clk) begin
    if (!rstN)            filtAcc <= '0;
    else if (analogValid) filtAcc <= filtSum[ACC_W-1:0];
  end

  // applied codes and mute ramp
  logic [CODE_W-1:0] attL, attR;
  logic [CODE_W-1:0] nextL, nextR;
  logic [CODE_W-1:0] tgtL, tgtR;
  muteState_t        state, stateNext;

  assign tgtL = analogMode ? filtCode : volCodeL;
  assign tgtR = analogMode ? filtCode : volCodeR;

  function automatic logic [CODE_W-1:0] stepCode(
    input logic [CODE_W-1:0] cur, input logic [CODE_W-1:0] tgt,
    input logic mute, input logic follow);
    if (mute)        return (cur == MUTE_CODE) ? MUTE_CODE : cur + 1'b1;
    else if (follow) return tgt;
    else             return (cur > tgt) ? cur - 1'b1 : tgt;
  endfunction

  always_comb begin
    nextL = stepCode(attL, tgtL, softMute, state == ST_NORMAL);
    nextR = stepCode(attR, tgtR, softMute, state == ST_NORMAL);
    if (softMute)
      stateNext = (nextL == MUTE_CODE && nextR == MUTE_CODE) ? ST_MUTED : ST_MUTING;
    else if (state == ST_NORMAL)
      stateNext = ST_NORMAL;
    else
      stateNext = (nextL == tgtL && nextR == tgtR) ? ST_NORMAL : ST_DEMUTING;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      attL  <= '0;
      attR  <= '0;
      state <= ST_NORMAL;
    end else if (sampleValid) begin
      attL  <= nextL;
      attR  <= nextR;
      state <= stateNext;
    end
  end

  assign strobes.frame = sampleValid;
  assign strobes.codeL = attL;
  assign strobes.codeR = attR;
  assign rampBusy  = (state == ST_MUTING) || (state == ST_DEMUTING);
  assign softMuted = (state == ST_MUTED);

  // R6: a mute frame raises the applied code by one until mute
  a_r6_mute_step: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid && softMute |=>
      (attL == $past(attL) + 1'b1) || (attL == MUTE_CODE && $past(attL) == MUTE_CODE));

  // R6: muted flag only with both channels at mute
  a_r6_muted_level: assert property (@(posedge clk) disable iff (!rstN)
    softMuted |-> (attL == MUTE_CODE) && (attR == MUTE_CODE));

  // R7: during demute the code never rises
  a_r7_demute_down: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid && !softMute && state != ST_NORMAL |=> attR <= $past(attR));

  // R5: codes move only on frames
  a_r5_code_hold: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> $stable(attL) && $stable(attR));
endmodule

// File: rtl/volDatapath.sv
module volDatapath
  import volPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  volStrobes_t       strobes,
  input  logic [DATA_W-1:0] inL,
  input  logic [DATA_W-1:0] inR,
  output logic [DATA_W-1:0] outL,
  output logic [DATA_W-1:0] outR,
  output logic              outValid
);
  localparam int PROD_W = DATA_W + GAIN_W + 1;

  logic [DATA_W-1:0] chIn   [2];
  logic [CODE_W-1:0] chCode [2];
  logic [DATA_W-1:0] chOut  [2];

  assign chIn[0]   = inL;
  assign chIn[1]   = inR;
  assign chCode[0] = strobes.codeL;
  assign chCode[1] = strobes.codeR;

  for (genvar c = 0; c < 2; c++) begin : g_chan
    logic [GAIN_W-1:0]       gain;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] scaled;
    logic [DATA_W-1:0]       satVal;
    logic [DATA_W-1:0]       outReg;

    assign gain   = codeToGain(chCode[c]);
    assign prod   = $signed(chIn[c]) * $signed({1'b0, gain});
    assign scaled = prod >>> GAIN_FRAC;

    always_comb begin
      if (scaled[PROD_W-1:DATA_W-1] == '0 || scaled[PROD_W-1:DATA_W-1] == '1)
        satVal = scaled[DATA_W-1:0];
      else if (scaled[PROD_W-1])
        satVal = {1'b1, {(DATA_W-1){1'b0}}};
      else
        satVal = {1'b0, {(DATA_W-1){1'b1}}};
    end

    always_ff @(posedge clk) begin
      if (!rstN)              outReg <= '0;
      else if (strobes.frame) outReg <= satVal;
    end

    assign chOut[c] = outReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= strobes.frame;
  end

  assign outL = chOut[0];
  assign outR = chOut[1];

  // R3: a frame scaled at the mute code yields silence
  a_r3_mute_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobes.frame && strobes.codeL == MUTE_CODE |=> outL == '0);

  // R9: outputs hold between frames
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.frame |=> $stable(outL) && $stable(outR));
endmodule

// File: rtl/stereo_volume.sv
module stereo_volume
  import volPkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int FILT_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] inL,
  input  logic [DATA_W-1:0] inR,
  input  logic [CODE_W-1:0] volCodeL,
  input  logic [CODE_W-1:0] volCodeR,
  input  logic              softMute,
  input  logic              analogMode,
  input  logic              analogValid,
  input  logic [CODE_W-1:0] analogLevel,
  output logic [DATA_W-1:0] outL,
  output logic [DATA_W-1:0] outR,
  output logic              outValid,
  output logic              rampBusy,
  output logic              softMuted
);
  volStrobes_t strobes;

  volCtrl #(.FILT_SHIFT(FILT_SHIFT)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .softMute(softMute),
    .analogMode(analogMode), .analogValid(analogValid), .analogLevel(analogLevel),
    .volCodeL(volCodeL), .volCodeR(volCodeR), .strobes(strobes),
    .rampBusy(rampBusy), .softMuted(softMuted)
  );

  volDatapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .inL(inL), .inR(inR),
    .outL(outL), .outR(outR), .outValid(outValid)
  );
endmodule

// File: tb/stereo_volume_tb.sv
`timescale 1ns/1ps
module stereo_volume_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic [15:0] inL = '0, inR = '0;
  logic [7:0] volCodeL = '0, volCodeR = '0;
  logic softMute = 1'b0, analogMode = 1'b0, analogValid = 1'b0;
  logic [7:0] analogLevel = '0;
  logic [15:0] outL, outR;
  logic outValid, rampBusy, softMuted;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  stereo_volume u_dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .inL(inL), .inR(inR),
    .volCodeL(volCodeL), .volCodeR(volCodeR), .softMute(softMute),
    .analogMode(analogMode), .analogValid(analogValid), .analogLevel(analogLevel),
    .outL(outL), .outR(outR), .outValid(outValid), .rampBusy(rampBusy),
    .softMuted(softMuted)
  );

  function automatic longint expGain(int code);
    longint m;
    if (code == 255) return 0;
    case (code % 12)
      0: m = 32768;  1: m = 30935;  2: m = 29205;  3: m = 27571;
      4: m = 26029;  5: m = 24573;  6: m = 23198;  7: m = 21900;
      8: m = 20675;  9: m = 19519;  10: m = 18427; default: m = 17396;
    endcase
    return m >> (code / 12);
  endfunction

  function automatic int expOut(int s, int code);
    longint p;
    p = longint'(s) * expGain(code);
    p = p >>> 15;
    return int'(p);
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic frame(int l, int r);
    @(negedge clk);
    sampleValid = 1'b1; inL = 16'(l); inR = 16'(r);
    @(negedge clk);
    sampleValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic ctlUpdate(int lvl);
    @(negedge clk);
    analogValid = 1'b1; analogLevel = 8'(lvl);
    @(negedge clk);
    analogValid = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 outL", int'(outL), 0);
    check("R1 outR", int'(outR), 0);
    check("R1 outValid", int'(outValid), 0);
    check("R1 rampBusy", int'(rampBusy), 0);
    check("R1 softMuted", int'(softMuted), 0);
    frame(1234, -777);
    check("R1 unity L", $signed(outL), 1234);
    check("R1 unity R", $signed(outR), -777);
  endtask

  task automatic t_gainLaw();
    int codes[8] = '{0, 1, 11, 12, 25, 100, 200, 254};
    int samp[4]  = '{16384, -32768, 32767, -12345};
    foreach (codes[i]) begin
      volCodeL = 8'(codes[i]);
      volCodeR = 8'(codes[7 - i]);
      frame(0, 0);
      frame(samp[i % 4], samp[(i + 1) % 4]);
      check("R2 gain L", $signed(outL), expOut(samp[i % 4], codes[i]));
      check("R4 gain R", $signed(outR), expOut(samp[(i + 1) % 4], codes[7 - i]));
    end
  endtask

  task automatic t_muteCode();
    volCodeL = 8'd255; volCodeR = 8'd0;
    frame(0, 0);
    frame(-32768, 500);
    check("R3 mute L", $signed(outL), 0);
    check("R4 other channel R", $signed(outR), 500);
    volCodeL = 8'd0; volCodeR = 8'd255;
    frame(0, 0);
    frame(32767, 32767);
    check("R3 mute R", $signed(outR), 0);
    check("R4 other channel L", $signed(outL), 32767);
  endtask

  task automatic t_boundary();
    volCodeL = 8'd0; volCodeR = 8'd0;
    frame(0, 0);
    volCodeL = 8'd24; volCodeR = 8'd6;
    frame(16384, 16384);
    check("R5 old code L", $signed(outL), 16384);
    frame(16384, 16384);
    check("R5 new code L", $signed(outL), expOut(16384, 24));
    check("R5 new code R", $signed(outR), expOut(16384, 6));
  endtask

  task automatic t_valid();
    @(negedge clk);
    sampleValid = 1'b1; inL = 16'd100; inR = 16'd200;
    volCodeL = 8'd0; volCodeR = 8'd0;
    @(negedge clk);
    sampleValid = 1'b0; inL = 16'd9; inR = 16'd9;
    check("R9 outValid high", int'(outValid), 1);
    @(negedge clk);
    check("R9 outValid low", int'(outValid), 0);
    repeat (3) @(negedge clk);
    check("R9 hold L", $signed(outL), expOut(100, 24));
    check("R9 hold R", $signed(outR), expOut(200, 6));
  endtask

  task automatic t_softMute();
    volCodeL = 8'd10; volCodeR = 8'd20;
    frame(0, 0);
    softMute = 1'b1;
    frame(0, 0);
    check("R6 busy after first", int'(rampBusy), 1);
    frame(16384, 16384);
    check("R6 ramp L", $signed(outL), expOut(16384, 11));
    check("R6 ramp R", $signed(outR), expOut(16384, 21));
    for (int k = 3; k < 245; k++) frame(0, 0);
    check("R6 busy at 244", int'(rampBusy), 1);
    check("R6 not muted at 244", int'(softMuted), 0);
    frame(0, 0);
    check("R6 muted at 245", int'(softMuted), 1);
    check("R6 busy off at 245", int'(rampBusy), 0);
    frame(-32768, 32767);
    check("R6 silent L", $signed(outL), 0);
    check("R6 silent R", $signed(outR), 0);
    softMute = 1'b0;
    frame(0, 0);
    check("R7 busy on release", int'(rampBusy), 1);
    check("R7 muted off", int'(softMuted), 0);
    for (int k = 2; k <= 100; k++) frame(0, 0);
    frame(16384, 16384);
    check("R7 mid ramp L", $signed(outL), expOut(16384, 155));
    check("R7 mid ramp R", $signed(outR), expOut(16384, 155));
    for (int k = 102; k < 245; k++) frame(0, 0);
    check("R7 busy at 244", int'(rampBusy), 1);
    frame(0, 0);
    check("R7 done at 245", int'(rampBusy), 0);
    frame(16384, 16384);
    check("R7 back L", $signed(outL), expOut(16384, 10));
    check("R7 back R", $signed(outR), expOut(16384, 20));
    volCodeL = 8'd0;
    frame(0, 0);
    frame(300, 0);
    check("R7 follows again", $signed(outL), 300);
  endtask

  task automatic t_analog();
    analogMode = 1'b1;
    ctlUpdate(20);
    frame(0, 0);
    frame(16384, 16384);
    check("R8 first update L", $signed(outL), expOut(16384, 1));
    check("R8 first update R", $signed(outR), expOut(16384, 1));
    for (int k = 0; k < 200; k++) ctlUpdate(20);
    frame(0, 0);
    frame(16384, -16384);
    check("R8 settled L", $signed(outL), expOut(16384, 19));
    check("R8 settled R", $signed(outR), expOut(-16384, 19));
    analogMode = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_analog();
    t_gainLaw();
    t_muteCode();
    t_boundary();
    t_valid();
    t_softMute();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule